// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block chooses which of N occupied slots to give up when a new occupant needs room. It approximates least-recently-used order with the clock scheme. Each slot carries one accessed bit, which a touch input raises. A hand pointer sweeps the slots in a ring. A slot whose bit is raised is spared once: its bit is lowered and the hand moves on. The first slot found with a lowered bit is the victim.

A requester pulses `req` while the block is idle. The block then tests one slot per clock cycle. It reports the chosen slot on `victim_idx` with a one-cycle `done` pulse. The chosen slot's accessed bit is raised on behalf of its new occupant, and the hand is left one past it, so the next search begins there. Touches may arrive at any time, including during a scan.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset every accessed bit is 0, the hand is at slot 0, `busy` and `done` are 0 and `victim_idx` is 0, so the first request returns slot 0.
- R2: A touch (`touch_en` high with `touch_idx` below N) raises that slot's accessed bit; a touch with an index of N or more has no effect.
- R3: A request sampled while idle raises `busy` on the next cycle. From then on one slot is tested per cycle, starting at the hand. Testing a slot whose bit is 0 ends the scan: `done` is high for exactly one cycle, `victim_idx` gives that slot, and `victim_idx` holds its value until the next `done`.
- R4: Testing a slot whose bit is 1 lowers that bit, advances the hand and does not pick that slot.
- R5: After a victim is chosen, the hand stands one slot past it, and the next request starts its search there.
- R6: The hand moves from slot N-1 to slot 0.
- R7: If k slots with bit 1 are skipped before the victim, `done` rises k+1 clock edges after the edge that samples the request. With all bits at 1 and no touches, one full revolution clears them all and the starting slot is chosen after N+1 tests.
- R8: The chosen slot's accessed bit is set to 1 in the cycle it is chosen.
- R9: When a touch and a scan's clear reach the same slot in the same cycle, the touch wins and the bit stays 1.
- R10: A request that arrives while a scan is in progress is ignored. It neither restarts the scan nor queues a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| touch_en | input | 1 | Marks slot `touch_idx` as recently used |
| touch_idx | input | IDX_W | Slot being touched |
| req | input | 1 | Start a victim search (sampled when idle) |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle strobe: `victim_idx` is valid and new |
| victim_idx | output | IDX_W | Slot chosen by the latest search |

## Verification
A scan's clear and an outside touch can hit the same slot in the same cycle. The bench provokes this by making every slot recently used and then touching the slot under the hand in the very first test cycle of a search. If the touch wins, that slot survives the first revolution and is only cleared on the second. The victim then becomes the following slot, and the latency is one cycle longer than for a plain full revolution. The bench checks both the slot number and that latency. A reference model of bits and hand, run over every accessed-bit pattern with several starting hand positions, predicts each victim and its latency.

// File: rtl/csel_pkg.sv
package csel_pkg;
    typedef enum logic {
        SC_IDLE = 1'b0,
        SC_SCAN = 1'b1
    } scan_state_e;
endpackage

// File: rtl/csel_ref_bits.sv
module csel_ref_bits #(
    parameter int N_SLOTS = 8,
    parameter int IDX_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    input  logic               set_en,
    input  logic [IDX_W-1:0]   set_idx,
    output logic [N_SLOTS-1:0] bits_q
);
    logic [N_SLOTS-1:0] bits_d;
    logic               touch_ok;

    assign touch_ok = touch_en && (int'(touch_idx) < N_SLOTS);

    always_comb begin
        bits_d = bits_q;
        for (int i = 0; i < N_SLOTS; i++) begin
            if ((touch_ok && int'(touch_idx) == i) ||
                (set_en && int'(set_idx) == i)) begin
                bits_d[i] = 1'b1;
            end else if (clr_en && int'(clr_idx) == i) begin
                bits_d[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    // R2
    touch_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch_ok |=> bits_q[$past(touch_idx)]);

    // R4
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(touch_ok && touch_idx == clr_idx) && !(set_en && set_idx == clr_idx))
        |=> !bits_q[$past(clr_idx)]);

    // R9
    touch_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && touch_ok && touch_idx == clr_idx) |=> bits_q[$past(clr_idx)]);

    // R8
    victim_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> bits_q[$past(set_idx)]);
endmodule

// File: rtl/csel_hand.sv
module csel_hand #(
    parameter int N_SLOTS = 8,
    parameter int IDX_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] hand_q
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SLOTS - 1);

    logic [IDX_W-1:0] hand_d;

    always_comb begin
        hand_d = hand_q;
        if (step) begin
            if (hand_q == LAST) hand_d = '0;
            else                hand_d = hand_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hand_q <= '0;
        else        hand_q <= hand_d;
    end

    // R6
    hand_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(hand_q) < N_SLOTS);

    // R6
    hand_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && hand_q == LAST) |=> (hand_q == '0));

    // R5
    hand_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && hand_q != LAST) |=> (int'(hand_q) == int'($past(hand_q)) + 1));

    // R5
    hand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(hand_q));
endmodule

// File: rtl/csel_scan_ctrl.sv
module csel_scan_ctrl
    import csel_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int IDX_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             cur_bit,
    input  logic [IDX_W-1:0] hand,
    output logic             clr_en,
    output logic             set_en,
    output logic             step,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] victim_idx
);
    typedef struct packed {
        scan_state_e      st;
        logic             done;
        logic [IDX_W-1:0] victim;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        clr_en     = 1'b0;
        set_en     = 1'b0;
        step       = 1'b0;
        unique case (ctl_q.st)
            SC_IDLE: begin
                if (req) ctl_d.st = SC_SCAN;
            end
            SC_SCAN: begin
                step = 1'b1;
                if (cur_bit) begin
                    clr_en = 1'b1;
                end else begin
                    set_en       = 1'b1;
                    ctl_d.done   = 1'b1;
                    ctl_d.victim = hand;
                    ctl_d.st     = SC_IDLE;
                end
            end
            default: ctl_d.st = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st     <= SC_IDLE;
            ctl_q.done   <= 1'b0;
            ctl_q.victim <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy       = (ctl_q.st == SC_SCAN);
    assign done       = ctl_q.done;
    assign victim_idx = ctl_q.victim;

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    done_after_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R3
    victim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(victim_idx));

    // R3
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req) |=> busy);

    // R10
    scan_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cur_bit) |=> (busy && !done));
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
    parameter int N_SLOTS = 8,
    parameter int IDX_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             req,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] victim_idx
);
    logic [N_SLOTS-1:0] ref_q;
    logic [IDX_W-1:0]   hand_q;
    logic               clr_en;
    logic               set_en;
    logic               step;
    logic               cur_bit;

    assign cur_bit = ref_q[hand_q];

    csel_ref_bits #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .clr_en    (clr_en),
        .clr_idx   (hand_q),
        .set_en    (set_en),
        .set_idx   (hand_q),
        .bits_q    (ref_q)
    );

    csel_hand #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_hand (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .hand_q (hand_q)
    );

    csel_scan_ctrl #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .cur_bit    (cur_bit),
        .hand       (hand_q),
        .clr_en     (clr_en),
        .set_en     (set_en),
        .step       (step),
        .busy       (busy),
        .done       (done),
        .victim_idx (victim_idx)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && victim_idx == '0));
endmodule

// File: tb/clock_victim_sel_test.sv
module clock_victim_sel_test;
    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          touch_en = 1'b0;
    logic [IW-1:0] touch_idx = '0;
    logic          req = 1'b0;
    logic          busy;
    logic          done;
    logic [IW-1:0] victim_idx;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    bit  mb [N];
    int  mh;

    always #2.5 clk = ~clk;

    clock_victim_sel #(.N_SLOTS(N), .IDX_W(IW)) uut (
        .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
        .req(req), .busy(busy), .done(done), .victim_idx(victim_idx)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; req = 1'b0; touch_en = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < N; i++) mb[i] = 1'b0;
        mh = 0;
    endtask

    task automatic touch(input int idx);
        touch_en = 1'b1; touch_idx = IW'(idx);
        @(negedge clk);
        touch_en = 1'b0;
        if (idx < N) mb[idx] = 1'b1;
    endtask

    // model of the requirements: returns expected victim and latency
    task automatic model_scan(output int vic, output int lat);
        int k = 0;
        while (mb[mh]) begin
            mb[mh] = 1'b0;
            mh = (mh == N - 1) ? 0 : mh + 1;
            k++;
        end
        vic = mh;
        mb[mh] = 1'b1;
        mh = (mh == N - 1) ? 0 : mh + 1;
        lat = k + 1;
    endtask

    // issue request; optional touch during first test cycle; optional second req mid-scan
    task automatic request(input bit tch, input int tidx, input bit rereq,
                           output int vic, output int lat);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        if (tch) begin touch_en = 1'b1; touch_idx = IW'(tidx); end
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            touch_en = 1'b0;
            if (rereq && lat == 3) req = 1'b1;
            else                   req = 1'b0;
            lat++;
        end
        touch_en = 1'b0;
        req = 1'b0;
        vic = int'(victim_idx);
    endtask

    task automatic run_and_check(input string tag);
        int v, l, ev, el;
        request(1'b0, 0, 1'b0, v, l);
        model_scan(ev, el);
        check({tag, " victim"}, v, ev);
        check({tag, " latency"}, l, el);
        @(negedge clk);
        check("R3 done one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int v, l;
        do_reset();
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 victim", int'(victim_idx), 0);
        // R1 first request returns slot 0 in one test
        run_and_check("R1");
        check("R3 busy after done", int'(busy), 0);

        // R7 all-set full revolution, then R8: victims marked used
        do_reset();
        for (int i = 0; i < N; i++) touch(i);
        run_and_check("R7 full revolution");
        for (int i = 1; i < N; i++) run_and_check("R6 R5 sequential");
        run_and_check("R8 victims re-marked");

        // R2 out-of-range touch: N=8 fills 3 bits, so use a 4-slot-like check via reset then wrap
        do_reset();
        touch(2);
        run_and_check("R2 touched slot skipped");
        run_and_check("R5 next search after victim");

        // R9 touch wins over clear on the slot under the hand
        do_reset();
        for (int i = 0; i < N; i++) touch(i);
        request(1'b1, 0, 1'b0, v, l);
        check("R9 victim", v, 1);
        check("R9 latency", l, N + 2);

        // R10 request during scan ignored
        do_reset();
        for (int i = 0; i < N; i++) touch(i);
        request(1'b0, 0, 1'b1, v, l);
        check("R10 victim", v, 0);
        check("R10 latency", l, N + 1);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check("R10 no second scan busy", int'(busy), 0);
            check("R10 no second done", int'(done), 0);
        end

        // exhaustive sweep over bit patterns and starting hands (R2 R3 R4 R5 R6 R7)
        for (int pat = 0; pat < (1 << N); pat++) begin
            do_reset();
            for (int d = 0; d < (pat % N); d++) run_and_check("R5 pre-advance");
            for (int i = 0; i < N; i++) if (pat[i]) touch(i);
            run_and_check("R4 sweep first");
            run_and_check("R6 sweep second");
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule